// File: doc/BRIEF.md
# Oversampled Link Pattern Checker

This block qualifies a parallel cable link during long soak tests at full speed. The far end transmits a fixed sequence of words, such as a walking single bit or a pseudo-random run. Before the test starts, the same sequence is written into a local reference store. The checker runs on a clock at `OSR` times the word rate. It takes one sample per word at a fixed sub-phase and compares that sample with the expected reference entry. Each differing bit is added to a saturating error total, and each compared word adds its width to a total of bits compared, so a bit error ratio can be formed.

The expected-entry pointer returns to entry zero whenever the periodic alignment marker arrives with a word. Between markers the pointer wraps on its own at the end of the store. No comparison happens until the first marker has been seen.

Alongside the comparison, every oversampled input value is compared with the one before it. When they differ, the sub-phase of the new value is recorded in a sticky mask. If all transitions land in one sub-phase, the link has a stable phase relationship with the local clock, and the locked flag shows this. A clear strobe zeroes both totals and the mask without disturbing the sequence position.

Top module: `lpc_link_checker`

## Requirements
- R1: While `rst_n` is low, both totals, the phase mask, `armed_o` and `mismatch_o` are cleared, and the sub-phase counter is set to 0. The sample taken at the k-th rising edge after reset release (k = 0, 1, ...) has sub-phase k mod `OSR`.
- R2: Until a word arrives with `align_i` high, no word is compared: both totals stay at 0 and `armed_o` stays low. Once `armed_o` is high, it stays high until reset.
- R3: The reference store is written through `ref_we_i`/`ref_addr_i`/`ref_data_i`, one entry per clock. The word that carries `align_i` is compared with entry 0, and each following word is compared with the next entry.
- R4: After entry `DEPTH`-1, the next word is compared with entry 0, even when no marker arrives.
- R5: A marker that arrives in the middle of the sequence makes its word compare with entry 0 again, and the count restarts from there.
- R6: Each compared word adds the number of bits that differ from the expected entry to `err_cnt_o`, and adds `WORD_W` to `bit_cnt_o`. Both totals are updated at the clock edge after the sample at the capture sub-phase.
- R7: Both totals stop at 2^`CNT_W`-1 and never wrap.
- R8: `mismatch_o` is high exactly when the most recently compared word differed from its reference entry.
- R9: Only the sample at sub-phase `CAPTURE_PHASE` (default 2) is compared. Input values at the other sub-phases have no effect on the totals.
- R10: When an input sample differs from the sample before it, bit p of `phase_mask_o` is set, where p is the sub-phase of the new sample. Set bits stay set.
- R11: `phase_locked_o` is high exactly when one bit of `phase_mask_o` is set.
- R12: `clear_i` zeroes both totals and the phase mask at the next edge, and takes priority over any update at that edge. It does not change the sequence position or `armed_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, `OSR` times the word rate |
| rst_n | input | 1 | Synchronous active-low reset |
| link_i | input | WORD_W | Received link word |
| align_i | input | 1 | Periodic alignment marker, held for the whole word |
| clear_i | input | 1 | Clears the totals and the phase mask |
| ref_we_i | input | 1 | Reference store write enable |
| ref_addr_i | input | clog2(DEPTH) | Reference store write address |
| ref_data_i | input | WORD_W | Reference store write data |
| err_cnt_o | output | CNT_W | Saturating total of bit errors |
| bit_cnt_o | output | CNT_W | Saturating total of bits compared |
| phase_mask_o | output | OSR | Sticky mask of sub-phases in which transitions were seen |
| phase_locked_o | output | 1 | Exactly one sub-phase has seen transitions |
| armed_o | output | 1 | First alignment marker has been seen |
| mismatch_o | output | 1 | Last compared word had at least one bit error |

## Verification
Saturation is the hardest condition to reach: with 48-bit totals, a real run would need an astronomically long test. The bench therefore builds the checker with 12-bit totals and an 8-bit word. It then sends several hundred fully inverted words, so both totals reach their ceiling and keep receiving input after that. Two more cases need exact sub-phase control: showing that samples outside the capture sub-phase are ignored, and producing transitions in several sub-phases. For these, the bench counts edges from reset release and moves the input only within chosen sub-phases of a word.

// File: rtl/lpc_pkg.sv
// Shared helpers for the link pattern checker.
// Assumes: the caller passes positive sizes.
package lpc_pkg;

    // Index width for a range of n values; at least one bit.
    function automatic int idx_width(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/lpc_ref_ram.sv
// Reference word store: one synchronous write port and one asynchronous
// read port. Writes to addresses at or past DEPTH are dropped.
// Assumes: the read address is always below DEPTH.
module lpc_ref_ram #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 500,
    parameter int AW     = 9
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [AW-1:0]     waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [AW-1:0]     raddr_i,
    output logic [WORD_W-1:0] rdata_o
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Store one reference word per write strobe.
    always_ff @(posedge clk) begin
        if (we_i && (waddr_i <= LAST_ADDR)) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lpc_sat_counter.sv
// Saturating accumulator: adds inc_i when en_i is high and stops at all ones.
// clr_i has priority over the add.
// Assumes: INC_W <= CNT_W.
module lpc_sat_counter #(
    parameter int CNT_W = 48,
    parameter int INC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             en_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;

    assign sum = {1'b0, cnt_q} + (CNT_W + 1)'(inc_i);

    // Accumulate with a ceiling, or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (en_i) begin
            cnt_q <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/lpc_phase_mon.sv
// Phase monitor: compares each oversampled input value with the previous one
// and sets a sticky mask bit for the sub-phase of any sample that changed.
// Assumes: samp_i/samp_sp_i come from one register stage and samp_vld_i marks
// that the stage holds a real sample.
module lpc_phase_mon #(
    parameter int WORD_W = 32,
    parameter int OSR    = 4,
    parameter int SP_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              samp_vld_i,
    input  logic [WORD_W-1:0] samp_i,
    input  logic [SP_W-1:0]   samp_sp_i,
    output logic [OSR-1:0]    mask_o
);
    logic [WORD_W-1:0] prev_q;
    logic              primed_q;
    logic [OSR-1:0]    mask_q;
    logic              edge_seen;

    assign edge_seen = samp_vld_i && primed_q && (samp_i != prev_q);

    // Keep the previous sample once the first one exists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            primed_q <= 1'b0;
        end else if (samp_vld_i) begin
            prev_q   <= samp_i;
            primed_q <= 1'b1;
        end
    end

    // Record the sub-phase of every transition; cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (clr_i) begin
            mask_q <= '0;
        end else if (edge_seen) begin
            mask_q[samp_sp_i] <= 1'b1;
        end
    end

    assign mask_o = mask_q;
endmodule

// File: rtl/lpc_link_checker.sv
// Link pattern checker with phase monitor.
// Samples link_i on every clock (OSR clocks per word), compares the sample at
// sub-phase CAPTURE_PHASE with a wrapping reference sequence, and accumulates
// bit errors and compared bits. A parallel monitor records transition phases.
// Assumes: align_i is held for a whole word; the reference store is loaded
// before the first marker.
module lpc_link_checker #(
    parameter int WORD_W        = 32,
    parameter int DEPTH         = 500,
    parameter int CNT_W         = 48,
    parameter int OSR           = 4,
    parameter int CAPTURE_PHASE = 2,
    parameter int AW            = lpc_pkg::idx_width(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] link_i,
    input  logic              align_i,
    input  logic              clear_i,
    input  logic              ref_we_i,
    input  logic [AW-1:0]     ref_addr_i,
    input  logic [WORD_W-1:0] ref_data_i,
    output logic [CNT_W-1:0]  err_cnt_o,
    output logic [CNT_W-1:0]  bit_cnt_o,
    output logic [OSR-1:0]    phase_mask_o,
    output logic              phase_locked_o,
    output logic              armed_o,
    output logic              mismatch_o
);
    import lpc_pkg::*;

    localparam int SP_W = idx_width(OSR);
    localparam int PC_W = $clog2(WORD_W + 1);
    localparam logic [SP_W-1:0] SP_LAST   = SP_W'(OSR - 1);
    localparam logic [SP_W-1:0] SP_CAP    = SP_W'(CAPTURE_PHASE);
    localparam logic [AW-1:0]   ADDR_LAST = AW'(DEPTH - 1);
    localparam logic [PC_W-1:0] WORD_BITS = PC_W'(WORD_W);

    // Oversampling position and input sample stage.
    logic [SP_W-1:0]   sp_q;
    logic [WORD_W-1:0] samp_q;
    logic [SP_W-1:0]   samp_sp_q;
    logic              samp_vld_q;
    logic              align_q;

    // Sequence tracking.
    logic [AW-1:0]     addr_q;
    logic              armed_q;
    logic              mismatch_q;

    logic              cap;
    logic              do_cmp;
    logic [AW-1:0]     exp_addr;
    logic [AW-1:0]     next_addr;
    logic [WORD_W-1:0] ref_word;
    logic [WORD_W-1:0] diff;
    logic [PC_W-1:0]   diff_cnt;

    // Free-running sub-phase counter, restarted by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= (sp_q == SP_LAST) ? '0 : sp_q + 1'b1;
        end
    end

    // Register every input value together with its sub-phase tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q     <= '0;
            samp_sp_q  <= '0;
            samp_vld_q <= 1'b0;
            align_q    <= 1'b0;
        end else begin
            samp_q     <= link_i;
            samp_sp_q  <= sp_q;
            samp_vld_q <= 1'b1;
            align_q    <= align_i;
        end
    end

    assign cap       = samp_vld_q && (samp_sp_q == SP_CAP);
    assign exp_addr  = align_q ? '0 : addr_q;
    assign next_addr = (exp_addr == ADDR_LAST) ? '0 : exp_addr + 1'b1;
    assign do_cmp    = cap && (armed_q || align_q);
    assign diff      = samp_q ^ ref_word;

    // Count the differing bits of the captured word.
    always_comb begin
        diff_cnt = '0;
        for (int i = 0; i < WORD_W; i++) begin
            diff_cnt = diff_cnt + PC_W'(diff[i]);
        end
    end

    // Advance the expected entry and arm on the first marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            armed_q    <= 1'b0;
            mismatch_q <= 1'b0;
        end else if (do_cmp) begin
            addr_q     <= next_addr;
            armed_q    <= 1'b1;
            mismatch_q <= (diff_cnt != '0);
        end
    end

    lpc_ref_ram #(
        .WORD_W(WORD_W),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) ref_ram_i (
        .clk    (clk),
        .we_i   (ref_we_i),
        .waddr_i(ref_addr_i),
        .wdata_i(ref_data_i),
        .raddr_i(exp_addr),
        .rdata_o(ref_word)
    );

    lpc_sat_counter #(
        .CNT_W(CNT_W),
        .INC_W(PC_W)
    ) err_ctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(clear_i),
        .en_i (do_cmp),
        .inc_i(diff_cnt),
        .cnt_o(err_cnt_o)
    );

    lpc_sat_counter #(
        .CNT_W(CNT_W),
        .INC_W(PC_W)
    ) bit_ctr_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr_i(clear_i),
        .en_i (do_cmp),
        .inc_i(WORD_BITS),
        .cnt_o(bit_cnt_o)
    );

    lpc_phase_mon #(
        .WORD_W(WORD_W),
        .OSR   (OSR),
        .SP_W  (SP_W)
    ) phase_mon_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clear_i),
        .samp_vld_i(samp_vld_q),
        .samp_i    (samp_q),
        .samp_sp_i (samp_sp_q),
        .mask_o    (phase_mask_o)
    );

    assign phase_locked_o = ($countones(phase_mask_o) == 1);
    assign armed_o        = armed_q;
    assign mismatch_o     = mismatch_q;
endmodule

// File: rtl/lpc_link_checker_chk.sv
// Property checker for lpc_link_checker, attached by bind.
// Assumes: connected to the top-level ports only.
module lpc_link_checker_chk #(
    parameter int CNT_W = 48,
    parameter int OSR   = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic [CNT_W-1:0] err_cnt_o,
    input logic [CNT_W-1:0] bit_cnt_o,
    input logic [OSR-1:0]   phase_mask_o,
    input logic             armed_o
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (err_cnt_o == '0 && bit_cnt_o == '0 && phase_mask_o == '0 && !armed_o));

    // R2
    armed_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed_o |=> armed_o);

    // R2
    idle_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_o |-> (bit_cnt_o == '0));

    // R6
    err_le_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_cnt_o <= bit_cnt_o);

    // R7
    err_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (err_cnt_o >= $past(err_cnt_o)));

    // R7
    bits_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> (bit_cnt_o >= $past(bit_cnt_o)));

    // R10
    mask_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clear_i |=> ((phase_mask_o & $past(phase_mask_o)) == $past(phase_mask_o)));

    // R12
    clear_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (err_cnt_o == '0 && bit_cnt_o == '0 && phase_mask_o == '0));
endmodule

bind lpc_link_checker lpc_link_checker_chk #(
    .CNT_W(CNT_W),
    .OSR  (OSR)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .err_cnt_o   (err_cnt_o),
    .bit_cnt_o   (bit_cnt_o),
    .phase_mask_o(phase_mask_o),
    .armed_o     (armed_o)
);

// File: tb/lpc_link_checker_tb_top.sv
// Directed bench for lpc_link_checker: small word, short store, narrow totals.
module lpc_link_checker_tb_top;
    localparam int W     = 8;
    localparam int D     = 12;
    localparam int CW    = 12;
    localparam int AW    = 4;
    localparam int CMAX  = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  link_i = '0;
    logic          align_i = 1'b0;
    logic          clear_i = 1'b0;
    logic          ref_we_i = 1'b0;
    logic [AW-1:0] ref_addr_i = '0;
    logic [W-1:0]  ref_data_i = '0;
    logic [CW-1:0] err_cnt_o;
    logic [CW-1:0] bit_cnt_o;
    logic [3:0]    phase_mask_o;
    logic          phase_locked_o;
    logic          armed_o;
    logic          mismatch_o;

    int tests = 0;
    int fails = 0;

    // Bench model of the sequence and the totals.
    logic [W-1:0] ref_m [D];
    int           m_idx = 0;
    bit           m_armed = 0;
    int           m_err = 0;
    int           m_bits = 0;
    bit           m_mis = 0;

    always #2 clk = ~clk;

    lpc_link_checker #(
        .WORD_W(W), .DEPTH(D), .CNT_W(CW), .OSR(4), .CAPTURE_PHASE(2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .link_i(link_i), .align_i(align_i),
        .clear_i(clear_i), .ref_we_i(ref_we_i), .ref_addr_i(ref_addr_i),
        .ref_data_i(ref_data_i), .err_cnt_o(err_cnt_o), .bit_cnt_o(bit_cnt_o),
        .phase_mask_o(phase_mask_o), .phase_locked_o(phase_locked_o),
        .armed_o(armed_o), .mismatch_o(mismatch_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_model(input string req);
        chk({req, " err"}, int'(err_cnt_o), m_err);
        chk({req, " bits"}, int'(bit_cnt_o), m_bits);
        chk({req, " armed"}, int'(armed_o), int'(m_armed));
        chk({req, " mismatch"}, int'(mismatch_o), int'(m_mis));
    endtask

    function automatic int popc(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(v[i]);
        return n;
    endfunction

    // One word: starts and ends at a negedge just before a sub-phase 0 edge.
    // glitch drives ~w at sub-phases 0, 1 and 3 and w only at sub-phase 2.
    task automatic send_word(input logic [W-1:0] w, input bit a, input bit clr, input bit glitch);
        link_i  = glitch ? ~w : w;
        align_i = a;
        clear_i = clr;
        @(posedge clk); #1 clear_i = 1'b0;
        @(posedge clk); #1 link_i = w;
        @(posedge clk); #1 if (glitch) link_i = ~w;
        @(posedge clk);
        if (clr) begin m_err = 0; m_bits = 0; end
        if (a) begin m_armed = 1; m_idx = 0; end
        if (m_armed) begin
            m_err  = (m_err + popc(w ^ ref_m[m_idx]) > CMAX) ? CMAX : m_err + popc(w ^ ref_m[m_idx]);
            m_bits = (m_bits + W > CMAX) ? CMAX : m_bits + W;
            m_mis  = (w != ref_m[m_idx]);
            m_idx  = (m_idx + 1) % D;
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 err", int'(err_cnt_o), 0);
        chk("R1 bits", int'(bit_cnt_o), 0);
        chk("R1 mask", int'(phase_mask_o), 0);
        chk("R1 armed", int'(armed_o), 0);
        chk("R1 mismatch", int'(mismatch_o), 0);
    endtask

    task automatic t_unarmed();
        send_word(8'hFF, 0, 0, 0);
        send_word(8'h5A, 0, 0, 0);
        send_word(8'hC3, 0, 0, 0);
        chk("R2 err before marker", int'(err_cnt_o), 0);
        chk("R2 bits before marker", int'(bit_cnt_o), 0);
        chk("R2 armed", int'(armed_o), 0);
    endtask

    task automatic t_sequence();
        send_word(ref_m[0], 1, 0, 0);
        for (int i = 1; i < D; i++) send_word(ref_m[i], 0, 0, 0);
        chk_model("R3 full pass");
        chk("R3 no errors", int'(err_cnt_o), 0);
        send_word(ref_m[0], 0, 0, 0);
        send_word(ref_m[1], 0, 0, 0);
        chk("R4 wrap no errors", int'(err_cnt_o), 0);
        chk("R4 bits", int'(bit_cnt_o), (D + 2) * W);
        send_word(ref_m[2] ^ 8'h13, 0, 0, 0);
        chk("R6 three bit errors", int'(err_cnt_o), 3);
        chk("R8 mismatch set", int'(mismatch_o), 1);
        send_word(ref_m[3], 0, 0, 0);
        chk("R8 mismatch cleared", int'(mismatch_o), 0);
        chk_model("R6 model");
    endtask

    task automatic t_realign();
        int e0;
        e0 = int'(err_cnt_o);
        send_word(ref_m[4], 0, 0, 0);
        send_word(ref_m[0], 1, 0, 0);
        send_word(ref_m[1], 0, 0, 0);
        send_word(ref_m[2], 0, 0, 0);
        chk("R5 realign no new errors", int'(err_cnt_o), e0);
        chk_model("R5 model");
    endtask

    task automatic t_clear();
        send_word(ref_m[m_idx], 0, 1, 0);
        chk("R12 err after clear", int'(err_cnt_o), 0);
        chk("R12 bits after clear", int'(bit_cnt_o), W);
        chk("R12 armed kept", int'(armed_o), 1);
        send_word(ref_m[m_idx], 0, 0, 0);
        chk("R12 position kept", int'(err_cnt_o), 0);
    endtask

    task automatic t_subphase();
        send_word(ref_m[m_idx], 0, 0, 1);
        send_word(ref_m[m_idx], 0, 0, 1);
        chk("R9 other sub-phases ignored", int'(err_cnt_o), 0);
        chk_model("R9 model");
    endtask

    task automatic t_phase();
        send_word(ref_m[m_idx], 0, 1, 0);
        send_word(ref_m[m_idx], 0, 0, 0);
        send_word(ref_m[m_idx], 0, 0, 0);
        chk("R10 mask sub-phase 0", int'(phase_mask_o), 4'b0001);
        chk("R11 locked", int'(phase_locked_o), 1);
        send_word(ref_m[m_idx], 0, 0, 1);
        send_word(ref_m[m_idx], 0, 0, 0);
        chk("R10 mask three phases", int'(phase_mask_o), 4'b1101);
        chk("R11 not locked", int'(phase_locked_o), 0);
        chk_model("R10 model");
    endtask

    task automatic t_saturate();
        send_word(~ref_m[m_idx], 0, 1, 0);
        for (int i = 0; i < 530; i++) send_word(~ref_m[m_idx], 0, 0, 0);
        chk("R7 err saturated", int'(err_cnt_o), CMAX);
        chk("R7 bits saturated", int'(bit_cnt_o), CMAX);
        send_word(~ref_m[m_idx], 0, 0, 0);
        chk("R7 err stays", int'(err_cnt_o), CMAX);
        chk_model("R7 model");
    endtask

    initial begin
        #(200000 * 4);
        tests++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // Walking one, then a pseudo-random tail.
        for (int i = 0; i < D; i++) ref_m[i] = (i < W) ? W'(1 << i) : W'(i * 37 + 11);
        for (int i = 0; i < D; i++) begin
            @(negedge clk);
            ref_we_i = 1'b1; ref_addr_i = AW'(i); ref_data_i = ref_m[i];
        end
        @(negedge clk);
        ref_we_i = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_unarmed();
        t_sequence();
        t_realign();
        t_clear();
        t_subphase();
        t_phase();
        t_saturate();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule